// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block collects up to 32 interrupt request lines into a single interrupt output for a processor. Each request line is captured into a status bit. Whether a line is edge-sensitive or level-sensitive is fixed per line by a parameter mask. Software programs an enable mask and a two-bit master gate, and clears captured events by writing ones to an acknowledge register. To find out what to service, software reads a vector register, which holds the index of the highest-priority pending line.

Access goes through a simple 32-bit register bus with a word address, a write strobe, a read strobe and registered read data. The enable mask can be written as a whole. It can also be changed one bit at a time through a set alias and a clear alias, so that drivers sharing the controller never need a read-modify-write.

Top module: `vec_irq_ctrl`

## Requirements
- R1: An edge-sensitive input (its bit set to 1 in EDGE_MASK) sets its status bit only on a low-to-high transition. While it stays high after an acknowledge, the status bit stays clear.
- R2: A level-sensitive input (its bit set to 0 in EDGE_MASK) sets its status bit on every cycle in which the input is high.
- R3: Writing a mask to word address 4 ORs it into the enable register. Writing a mask to word address 5 clears those enable bits. No other enable bit changes.
- R4: Writing a mask to word address 3 clears the matching status bits on the next clock. Writing all ones clears every status bit.
- R5: The interrupt output can be high only when both bit 0 and bit 1 of the master register (word address 7) are 1.
- R6: Reading word address 6 returns the index of the lowest-numbered pending input. When nothing is pending it returns 0xFFFFFFFF.
- R7: If a status bit receives a set condition and an acknowledge in the same cycle, it stays set.
- R8: Word address 1 reads status AND enable. Word addresses 0 (status) and 1 are read-only, and writes to them change nothing.
- R9: Reads of word addresses 3, 4 and 5 return zero.
- R10: The interrupt output is registered. It rises one clock after a bit becomes pending while the master gate is open.
- R11: After reset, status, enable and master are all zero, the output is low and the vector reads 0xFFFFFFFF. Writing word address 2 loads the enable register directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Interrupt request lines |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; read data is valid after the next clock |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt output to the processor |

## Verification
A wrong status bit shows up at the vector and pending reads on the next bus read. It also shows on the interrupt output one clock after it goes pending. A stale enable bit or master bit shows as an interrupt output that is high when it should be low, or low when it should be high, within two clocks of the write. The sweep over every enable mask with all status bits set checks the priority encoder against an independently computed lowest index. Per-input passes hold each line high across an acknowledge, which separates edge capture from level capture.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam logic [BUS_W-1:0] NO_VECTOR = '1;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS  = 3'd0,
    REG_PENDING = 3'd1,
    REG_ENABLE  = 3'd2,
    REG_ACK     = 3'd3,
    REG_SETEN   = 3'd4,
    REG_CLREN   = 3'd5,
    REG_VECTOR  = 3'd6,
    REG_MASTER  = 3'd7
  } vic_reg_e;

  // Index of the lowest set bit, or NO_VECTOR when the vector is empty.
  function automatic logic [BUS_W-1:0] lowest_index(input logic [BUS_W-1:0] v);
    logic [BUS_W-1:0] res;
    res = NO_VECTOR;
    for (int i = BUS_W - 1; i >= 0; i--) begin
      if (v[i]) res = i;
    end
    return res;
  endfunction

  // Output gate: both master bits must be set.
  function automatic logic gate_open(input logic [1:0] m);
    return m[0] & m[1];
  endfunction
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] set_o
);
  logic [N-1:0] status_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req_i[g];
      end
      assign set_o[g] = req_i[g] & ~prev_q;
    end else begin : g_level
      assign set_o[g] = req_i[g];
    end
  end

  // Set wins over acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~ack_i) | set_o;
  end

  assign status_o = status_q;
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  vic_reg_e     sel_i,
  input  logic [N-1:0] wmask_i,
  input  logic [1:0]   wmaster_i,
  output logic [N-1:0] enable_o,
  output logic [1:0]   master_o,
  output logic [N-1:0] ack_o
);
  logic [N-1:0] enable_q;
  logic [1:0]   master_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      master_q <= 2'b00;
    end else if (wr_i) begin
      case (sel_i)
        REG_ENABLE: enable_q <= wmask_i;
        REG_SETEN:  enable_q <= enable_q | wmask_i;
        REG_CLREN:  enable_q <= enable_q & ~wmask_i;
        REG_MASTER: master_q <= wmaster_i;
        default:    ;
      endcase
    end
  end

  assign ack_o    = (wr_i && sel_i == REG_ACK) ? wmask_i : '0;
  assign enable_o = enable_q;
  assign master_o = master_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]     pending_i,
  output logic             any_o,
  output logic [BUS_W-1:0] vec_o
);
  logic [BUS_W-1:0] pend_wide;

  always_comb begin
    pend_wide = '0;
    pend_wide[N-1:0] = pending_i;
  end

  assign vec_o = lowest_index(pend_wide);
  assign any_o = |pending_i;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [2:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  vic_reg_e           sel;
  logic [NUM_SRC-1:0] wr_data_lo;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] set_cond;
  logic [NUM_SRC-1:0] ack_mask;
  logic [NUM_SRC-1:0] enable;
  logic [NUM_SRC-1:0] pending;
  logic [1:0]         master;
  logic               any_pend;
  logic [BUS_W-1:0]   vec_num;
  logic [BUS_W-1:0]   rd_mux;
  logic [BUS_W-1:0]   rdata_q;
  logic               irq_q;
  logic               unused_wbits;

  assign sel          = vic_reg_e'(bus_addr);
  assign wr_data_lo   = bus_wdata[NUM_SRC-1:0];
  assign unused_wbits = ^bus_wdata;

  vic_capture #(.N(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .ack_i    (ack_mask),
    .status_o (status),
    .set_o    (set_cond)
  );

  vic_regs #(.N(NUM_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr),
    .sel_i     (sel),
    .wmask_i   (wr_data_lo),
    .wmaster_i (bus_wdata[1:0]),
    .enable_o  (enable),
    .master_o  (master),
    .ack_o     (ack_mask)
  );

  assign pending = status & enable;

  vic_prio #(.N(NUM_SRC)) u_prio (
    .pending_i (pending),
    .any_o     (any_pend),
    .vec_o     (vec_num)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_STATUS:  rd_mux[NUM_SRC-1:0] = status;
      REG_PENDING: rd_mux[NUM_SRC-1:0] = pending;
      REG_ENABLE:  rd_mux[NUM_SRC-1:0] = enable;
      REG_VECTOR:  rd_mux = vec_num;
      REG_MASTER:  rd_mux[1:0] = master;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= any_pend & gate_open(master);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vic_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   bus_addr,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [31:0]  bus_rdata,
  input logic [N-1:0] wr_data_lo,
  input logic [N-1:0] status,
  input logic [N-1:0] set_cond,
  input logic [N-1:0] ack_mask,
  input logic [N-1:0] enable,
  input logic [N-1:0] pending,
  input logic [1:0]   master,
  input logic [31:0]  vec_num,
  input logic         irq_o
);
  logic [31:0] pend_w;
  always_comb begin
    pend_w = '0;
    pend_w[N-1:0] = pending;
  end

  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4) |=> ((enable & $past(wr_data_lo)) == $past(wr_data_lo)));

  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd5) |=> ((enable & $past(wr_data_lo)) == '0));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=> ((status & $past(wr_data_lo & ~set_cond)) == '0));

  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(master) == 2'b11));

  assert_vec_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vec_num == NO_VECTOR));

  assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> (pend_w[vec_num[4:0]] && ((pend_w & ((32'd1 << vec_num[4:0]) - 32'd1)) == '0)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cond != '0) |=> ((status & $past(set_cond)) == $past(set_cond)));

  assert_alias_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 3'd3 || bus_addr == 3'd4 || bus_addr == 3'd5)) |=> (bus_rdata == '0));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending != '0) && master == 2'b11) |=> irq_o);

  assert_ack_only_via_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask != '0) |-> (bus_wr && bus_addr == 3'd3));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .wr_data_lo (wr_data_lo),
  .status     (status),
  .set_cond   (set_cond),
  .ack_mask   (ack_mask),
  .enable     (enable),
  .pending    (pending),
  .master     (master),
  .vec_num    (vec_num),
  .irq_o      (irq_o)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  localparam int N = 8;
  localparam logic [N-1:0] EDGES = 8'h0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .EDGE_MASK(EDGES)) u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [31:0] exp_vec(input logic [31:0] m);
    for (int k = 0; k < 32; k++) if (m[k]) return k;
    return 32'hFFFF_FFFF;
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    bus_read(3'd0, v); chk("R11 status after reset", v, 0);
    bus_read(3'd2, v); chk("R11 enable after reset", v, 0);
    bus_read(3'd7, v); chk("R11 master after reset", v, 0);
    bus_read(3'd6, v); chk("R11 vector after reset", v, 32'hFFFF_FFFF);
    chk("R11 irq after reset", irq, 0);

    // Per-input pass: R1 edge, R2 level, R7 set beats ack, R4 ack
    for (int i = 0; i < N; i++) begin
      bus_write(3'd3, 32'hFF);
      bus_write(3'd2, 32'd1 << i);
      bus_write(3'd7, 32'd3);
      @(negedge clk); req[i] = 1'b1;
      @(negedge clk);
      bus_read(3'd0, v); chk(EDGES[i] ? "R1 edge capture" : "R2 level capture", v, 32'd1 << i);
      bus_read(3'd6, v); chk("R6 single vector", v, i);
      chk("R10 irq on single pending", irq, 1);
      bus_write(3'd3, 32'd1 << i);
      @(negedge clk);
      bus_read(3'd0, v);
      if (EDGES[i]) chk("R1 held edge stays clear", v, 0);
      else          chk("R7 level held beats ack", v, 32'd1 << i);
      req[i] = 1'b0;
      bus_write(3'd3, 32'd1 << i);
      bus_read(3'd0, v); chk("R4 ack clears bit", v, 0);
      bus_read(3'd6, v); chk("R6 empty vector", v, 32'hFFFF_FFFF);
    end

    // R10: output latency
    bus_write(3'd2, 32'h20);
    @(negedge clk); req[5] = 1'b1;
    @(negedge clk); chk("R10 irq not yet high", irq, 0);
    @(negedge clk); chk("R10 irq one clock later", irq, 1);
    req[5] = 1'b0;
    bus_write(3'd3, 32'hFF);

    // R5: master gate sweep
    @(negedge clk); req[6] = 1'b1;
    @(negedge clk); req[6] = 1'b0;
    bus_write(3'd2, 32'h40);
    for (int m = 0; m < 4; m++) begin
      bus_write(3'd7, m);
      @(negedge clk);
      chk("R5 master gate", irq, (m == 3) ? 1 : 0);
    end
    bus_write(3'd3, 32'hFF);

    // R3 / R11 / R9: enable writes and aliases
    bus_write(3'd2, 32'h0F); bus_read(3'd2, v); chk("R11 direct enable", v, 32'h0F);
    bus_write(3'd4, 32'h30); bus_read(3'd2, v); chk("R3 set alias", v, 32'h3F);
    bus_write(3'd5, 32'h05); bus_read(3'd2, v); chk("R3 clear alias", v, 32'h3A);
    bus_read(3'd3, v); chk("R9 ack reads zero", v, 0);
    bus_read(3'd4, v); chk("R9 set alias reads zero", v, 0);
    bus_read(3'd5, v); chk("R9 clear alias reads zero", v, 0);
    bus_read(3'd2, v); chk("R9 reads leave enable", v, 32'h3A);

    // R6 / R8: sweep all enable masks with every status bit set
    @(negedge clk); req = '1;
    @(negedge clk); req = '0;
    bus_read(3'd0, v); chk("R1 R2 all captured", v, 32'hFF);
    for (int mask = 0; mask < 256; mask++) begin
      bus_write(3'd2, mask);
      bus_read(3'd1, v); chk("R8 pending", v, mask);
      bus_read(3'd6, v); chk("R6 lowest pending", v, exp_vec(mask));
      chk("R5 irq follows pending", irq, (mask != 0) ? 1 : 0);
    end

    // R8: status and pending are read-only
    bus_write(3'd0, 32'h0); bus_write(3'd1, 32'h0);
    bus_read(3'd0, v); chk("R8 status read-only", v, 32'hFF);

    // R4: partial and full acknowledge
    bus_write(3'd3, 32'h81); bus_read(3'd0, v); chk("R4 partial ack", v, 32'h7E);
    bus_write(3'd3, 32'hFFFF_FFFF); bus_read(3'd0, v); chk("R4 ack all ones", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule